// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

This block gathers interrupt requests from a parameterised set of request lines and from a small group of timer-compare match strobes. It holds them in a pending register and qualifies them against an enable register. It then picks the highest priority level that has a qualified request above the processor's current interrupt level. Every line has a fixed priority level and a fixed trigger kind, level-sensitive or edge-latched. Both come from parameters. Lines assigned to the non-maskable level ignore the enable register.

The result is a level number and a request flag for the core. Both are formed combinationally from the registered pending bits, the registered enable bits and the current-level input. A change on a request line or an enable write shows at the outputs one clock later. A change of the current level shows in the same cycle. Software acknowledge of edge-latched requests is modelled by a per-line synchronous clear input.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_ni is low, the pending and enable registers are zero, so irq_o is 0 and irq_level_o is 0.
- R2: A request line below NUM_ACTIVE that is high at a clock edge sets its pending bit at that edge.
- R3: A level-type line (bit clear in EDGE_MASK) that is low at a clock edge, with no timer strobe mapped onto it, has its pending bit cleared at that edge.
- R4: An edge-type line (bit set in EDGE_MASK) keeps its pending bit after the request drops, until a clock edge where its edge_clr_i bit is high. A request on the same edge wins over the clear, and clear bits of level-type lines have no effect.
- R5: Lines with index at or above NUM_ACTIVE never become pending, whatever their request or timer inputs.
- R6: A pending line is eligible only if its enable bit is set, except lines whose level equals NMI_LEVEL, which are eligible without enable.
- R7: irq_level_o is the highest level L, strictly above the threshold, for which some eligible line has level L. If no level qualifies, it is 0. irq_o is 1 exactly when irq_level_o is nonzero.
- R8: The threshold is cur_level_i, except that a cur_level_i at or above NMI_LEVEL is clamped to NMI_LEVEL-1. A pending non-maskable line therefore always raises irq_o.
- R9: A high timer_hit_i[t] at a clock edge acts as a request on line TIMER_LINE[t], with the line index packed at bits [t*IDX_W +: IDX_W].
- R10: en_we_i high at a clock edge loads en_wdata_i into the enable register. The new mask is seen by the outputs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_LINES | Request lines, one per interrupt |
| timer_hit_i | input | NUM_TIMERS | Timer-compare match strobes |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_LINES | Enable register write data |
| edge_clr_i | input | NUM_LINES | Per-line clear of edge-latched pending bits |
| cur_level_i | input | LVL_W | Processor current interrupt level |
| irq_level_o | output | LVL_W | Selected pending level, 0 when none |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench targets the following corner cases:
- A clear that arrives together with a fresh request on an edge line. A design that let the clear win would drop a new interrupt.
- A level line released while enabled. A design that latched it would assert irq_o forever.
- A non-maskable line with the enable register zero and cur_level_i at the top value. A design without the clamp or the enable bypass would never deliver it.
- A cur_level_i equal to the pending level, which must give 0; an off-by-one compare would fire at that level.
- Requests on lines at or above NUM_ACTIVE and timer strobes that must set the mapped line.
- Random traffic with sparse requests, random clears, random enable writes and random current levels, checked against a reference model of pending and eligibility.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned DEF_LINES = 32;
  localparam int unsigned DEF_LVL_W = 3;

  // default assignment: line i sits at level (i mod 7) + 1
  function automatic logic [DEF_LINES*DEF_LVL_W-1:0] default_levels();
    logic [DEF_LINES*DEF_LVL_W-1:0] v;
    v = '0;
    for (int i = 0; i < int'(DEF_LINES); i++) begin
      v[i*DEF_LVL_W +: DEF_LVL_W] = DEF_LVL_W'((i % 7) + 1);
    end
    return v;
  endfunction
endpackage

// File: rtl/prio_irq_timer_map.sv
module prio_irq_timer_map #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned IDX_W      = 5,
  parameter logic [NUM_TIMERS*IDX_W-1:0] TIMER_LINE = '0
) (
  input  logic [NUM_TIMERS-1:0] hit_i,
  output logic [NUM_LINES-1:0]  line_o
);
  always_comb begin
    line_o = '0;
    for (int t = 0; t < int'(NUM_TIMERS); t++) begin
      if (hit_i[t]) line_o[TIMER_LINE[t*IDX_W +: IDX_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/prio_irq_pending.sv
module prio_irq_pending #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_ACTIVE = 32,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_line
    localparam bit IS_ACT  = (i < int'(NUM_ACTIVE));
    localparam bit IS_EDGE = EDGE_MASK[i];
    logic nxt;
    // request wins over clear; level lines follow the input
    assign nxt = IS_ACT && (req_i[i] || (IS_EDGE && pend_o[i] && !clr_i[i]));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[i] <= 1'b0;
      else         pend_o[i] <= nxt;
    end
  end
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned MAX_LEVEL = 7,
  parameter int unsigned NMI_LEVEL = 7,
  parameter int unsigned LVL_W     = 3,
  parameter logic [NUM_LINES*LVL_W-1:0] LINE_LEVEL = '0
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic [LVL_W-1:0]     cur_level_i,
  output logic [LVL_W-1:0]     level_o
);
  localparam logic [LVL_W-1:0] NMI_L = LVL_W'(NMI_LEVEL);

  logic [NUM_LINES-1:0] lvl_mask [1:MAX_LEVEL];
  logic [NUM_LINES-1:0] nmi_mask;
  logic [NUM_LINES-1:0] elig;
  logic [LVL_W-1:0]     thr;

  for (genvar l = 1; l <= int'(MAX_LEVEL); l++) begin : g_lvl
    for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_bit
      assign lvl_mask[l][i] = (LINE_LEVEL[i*LVL_W +: LVL_W] == LVL_W'(l));
    end
  end

  if (NMI_LEVEL >= 1 && NMI_LEVEL <= MAX_LEVEL) begin : g_nmi
    assign nmi_mask = lvl_mask[NMI_LEVEL];
  end else begin : g_no_nmi
    assign nmi_mask = '0;
  end

  assign elig = pend_i & (en_i | nmi_mask);
  assign thr  = (cur_level_i >= NMI_L) ? NMI_L - 1'b1 : cur_level_i;

  // ascending scan, last hit is the highest qualifying level
  always_comb begin
    level_o = '0;
    for (int l = 1; l <= int'(MAX_LEVEL); l++) begin
      if (LVL_W'(l) > thr && |(lvl_mask[l] & elig)) level_o = LVL_W'(l);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_ACTIVE = 24,
  parameter int unsigned MAX_LEVEL  = 7,
  parameter int unsigned NMI_LEVEL  = 7,
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned LVL_W      = $clog2(MAX_LEVEL + 1),
  parameter int unsigned IDX_W      = $clog2(NUM_LINES),
  parameter logic [NUM_LINES*LVL_W-1:0]  LINE_LEVEL = prio_irq_pkg::default_levels(),
  parameter logic [NUM_LINES-1:0]        EDGE_MASK  = 32'hF0F0_F0F0,
  parameter logic [NUM_TIMERS*IDX_W-1:0] TIMER_LINE = {5'd12, 5'd5}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  irq_req_i,
  input  logic [NUM_TIMERS-1:0] timer_hit_i,
  input  logic                  en_we_i,
  input  logic [NUM_LINES-1:0]  en_wdata_i,
  input  logic [NUM_LINES-1:0]  edge_clr_i,
  input  logic [LVL_W-1:0]      cur_level_i,
  output logic [LVL_W-1:0]      irq_level_o,
  output logic                  irq_o
);
  logic [NUM_LINES-1:0] timer_lines;
  logic [NUM_LINES-1:0] req_all;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] en_q;

  prio_irq_timer_map #(
    .NUM_LINES(NUM_LINES), .NUM_TIMERS(NUM_TIMERS),
    .IDX_W(IDX_W), .TIMER_LINE(TIMER_LINE)
  ) u_tmap (
    .hit_i(timer_hit_i), .line_o(timer_lines)
  );

  assign req_all = irq_req_i | timer_lines;

  prio_irq_pending #(
    .NUM_LINES(NUM_LINES), .NUM_ACTIVE(NUM_ACTIVE), .EDGE_MASK(EDGE_MASK)
  ) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_all), .clr_i(edge_clr_i), .pend_o(pend_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  prio_irq_resolve #(
    .NUM_LINES(NUM_LINES), .MAX_LEVEL(MAX_LEVEL), .NMI_LEVEL(NMI_LEVEL),
    .LVL_W(LVL_W), .LINE_LEVEL(LINE_LEVEL)
  ) u_res (
    .pend_i(pend_q), .en_i(en_q), .cur_level_i(cur_level_i),
    .level_o(irq_level_o)
  );

  assign irq_o = |irq_level_o;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned NUM_ACTIVE = 24,
  parameter int unsigned MAX_LEVEL  = 7,
  parameter int unsigned NMI_LEVEL  = 7,
  parameter int unsigned NUM_TIMERS = 2,
  parameter int unsigned LVL_W      = 3,
  parameter int unsigned IDX_W      = 5,
  parameter logic [NUM_LINES*LVL_W-1:0]  LINE_LEVEL = '0,
  parameter logic [NUM_LINES-1:0]        EDGE_MASK  = '0,
  parameter logic [NUM_TIMERS*IDX_W-1:0] TIMER_LINE = '0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_LINES-1:0]  irq_req_i,
  input logic [NUM_TIMERS-1:0] timer_hit_i,
  input logic                  en_we_i,
  input logic [NUM_LINES-1:0]  en_wdata_i,
  input logic [NUM_LINES-1:0]  edge_clr_i,
  input logic [LVL_W-1:0]      cur_level_i,
  input logic [LVL_W-1:0]      irq_level_o,
  input logic                  irq_o,
  input logic [NUM_LINES-1:0]  pend_q,
  input logic [NUM_LINES-1:0]  en_q
);
  logic [NUM_LINES-1:0] act_m, nmi_m, tline_m, lvl_line_m;
  logic [LVL_W:0]       eff_thr;

  always_comb begin
    act_m = '0; nmi_m = '0; tline_m = '0;
    for (int i = 0; i < int'(NUM_LINES); i++) begin
      act_m[i] = (i < int'(NUM_ACTIVE));
      nmi_m[i] = (int'(LINE_LEVEL[i*LVL_W +: LVL_W]) == int'(NMI_LEVEL)) &&
                 (NMI_LEVEL <= MAX_LEVEL);
    end
    for (int t = 0; t < int'(NUM_TIMERS); t++) tline_m[TIMER_LINE[t*IDX_W +: IDX_W]] = 1'b1;
    lvl_line_m = act_m & ~EDGE_MASK & ~tline_m;
    eff_thr = (int'(cur_level_i) >= int'(NMI_LEVEL)) ? (LVL_W+1)'(NMI_LEVEL - 1)
                                                    : {1'b0, cur_level_i};
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_clear_r1: assert (pend_q == '0 && en_q == '0);
    end
  end

  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & lvl_line_m) == $past(irq_req_i & lvl_line_m)));

  p_edge_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & EDGE_MASK & ~edge_clr_i)) ==
              $past(pend_q & EDGE_MASK & ~edge_clr_i)));

  p_inactive_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~act_m) == '0);

  p_above_thr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ({1'b0, irq_level_o} > eff_thr));

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_level_o == '0));

  p_nmi_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & nmi_m) != '0) |-> irq_o);

  p_en_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> (en_q == $past(en_wdata_i)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .NUM_ACTIVE(NUM_ACTIVE), .MAX_LEVEL(MAX_LEVEL),
  .NMI_LEVEL(NMI_LEVEL), .NUM_TIMERS(NUM_TIMERS), .LVL_W(LVL_W), .IDX_W(IDX_W),
  .LINE_LEVEL(LINE_LEVEL), .EDGE_MASK(EDGE_MASK), .TIMER_LINE(TIMER_LINE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req_i), .timer_hit_i(timer_hit_i),
  .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .edge_clr_i(edge_clr_i),
  .cur_level_i(cur_level_i), .irq_level_o(irq_level_o), .irq_o(irq_o),
  .pend_q(pend_q), .en_q(en_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NL = 32, NA = 24, MAXL = 7, NMIL = 7, NT = 2, LW = 3, IW = 5;
  localparam logic [NL-1:0] EDGE_M = 32'hF0F0_F0F0;

  function automatic logic [NL*LW-1:0] mk_levels();
    logic [NL*LW-1:0] v;
    for (int i = 0; i < NL; i++) v[i*LW +: LW] = LW'((i % 7) + 1);
    return v;
  endfunction
  localparam logic [NL*LW-1:0] LVLS = mk_levels();

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [NL-1:0] irq_req_i = '0, en_wdata_i = '0, edge_clr_i = '0;
  logic [NT-1:0] timer_hit_i = '0;
  logic en_we_i = 1'b0;
  logic [LW-1:0] cur_level_i = '0;
  logic [LW-1:0] irq_level_o;
  logic irq_o;

  int total = 0, bad = 0;
  bit [NL-1:0] m_pend = '0, m_en = '0;

  always #2 clk_i = ~clk_i;

  prio_irq_ctrl #(
    .NUM_LINES(NL), .NUM_ACTIVE(NA), .MAX_LEVEL(MAXL), .NMI_LEVEL(NMIL),
    .NUM_TIMERS(NT), .LVL_W(LW), .IDX_W(IW), .LINE_LEVEL(LVLS),
    .EDGE_MASK(EDGE_M), .TIMER_LINE({5'd12, 5'd5})
  ) u_dut (.*);

  function automatic int lvl_of(int i);
    return (i % 7) + 1;
  endfunction

  function automatic int exp_level(bit [NL-1:0] p, bit [NL-1:0] e, int cur);
    int thr = (cur >= NMIL) ? NMIL - 1 : cur;
    for (int l = MAXL; l > thr; l--)
      for (int i = 0; i < NA; i++)
        if (lvl_of(i) == l && p[i] && (e[i] || l == NMIL)) return l;
    return 0;
  endfunction

  task automatic tick();
    bit [NL-1:0] req;
    @(posedge clk_i);
    req = irq_req_i;
    if (timer_hit_i[0]) req[5] = 1'b1;
    if (timer_hit_i[1]) req[12] = 1'b1;
    for (int i = 0; i < NL; i++)
      m_pend[i] = (i < NA) && (req[i] || (EDGE_M[i] && m_pend[i] && !edge_clr_i[i]));
    if (en_we_i) m_en = en_wdata_i;
    #1;
  endtask

  task automatic chk(string tag, int exp);
    total++;
    if (int'(irq_level_o) != exp || irq_o != (exp != 0)) begin
      bad++;
      $display("FAIL %s: level=%0d irq=%0b expected level=%0d irq=%0b",
               tag, irq_level_o, irq_o, exp, exp != 0);
    end
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    @(posedge clk_i); @(posedge clk_i); #1;
    chk("R1 reset", 0);
    rst_ni = 1'b1;
    void'($urandom(32'd20250));

    irq_req_i = 32'h4;                        // line 2, level 3, level type
    tick(); chk("R6 not enabled", 0);
    en_we_i = 1'b1; en_wdata_i = '1;
    tick(); en_we_i = 1'b0; chk("R10 enable write", 3);
    irq_req_i = '0;
    tick(); chk("R3 level release", 0);

    irq_req_i = 32'h10;                       // line 4, level 5, edge type
    tick(); chk("R2 set pending", 5);
    irq_req_i = '0;
    tick(); tick(); chk("R4 edge held", 5);
    edge_clr_i = ~32'h10;
    tick(); chk("R4 other clears", 5);
    edge_clr_i = 32'h10; irq_req_i = 32'h10;
    tick(); chk("R4 request beats clear", 5);
    irq_req_i = '0;
    tick(); chk("R4 cleared", 0);
    edge_clr_i = '0;

    irq_req_i = 32'h8100_0000;                // lines 24 and 31
    tick(); chk("R5 inactive lines", 0);
    irq_req_i = '0;

    en_we_i = 1'b1; en_wdata_i = '0;
    tick(); en_we_i = 1'b0;
    irq_req_i = 32'h40; cur_level_i = 3'd7;   // line 6 is non-maskable
    tick(); chk("R8 nmi at top level", 7);
    irq_req_i = '0;
    tick(); chk("R8 nmi latched", 7);
    edge_clr_i = 32'h40;
    tick(); chk("R4 nmi cleared", 0);
    edge_clr_i = '0; cur_level_i = '0;

    en_we_i = 1'b1; en_wdata_i = '1;
    tick(); en_we_i = 1'b0;
    irq_req_i = 32'h801;                      // lines 0 (L1) and 11 (L5)
    tick(); chk("R7 highest wins", 5);
    cur_level_i = 3'd5; #1; chk("R7 equal threshold", 0);
    cur_level_i = 3'd4; #1; chk("R7 below threshold", 5);
    cur_level_i = '0; irq_req_i = 32'h1;
    tick(); chk("R7 lowest level", 1);
    irq_req_i = '0;
    tick(); chk("R3 release", 0);

    timer_hit_i = 2'b01;
    tick(); timer_hit_i = '0; chk("R9 timer0 line 5", 6);
    edge_clr_i = 32'h20;
    tick(); chk("R9 timer0 cleared", 0);
    edge_clr_i = '0; timer_hit_i = 2'b10;
    tick(); timer_hit_i = '0; chk("R9 timer1 line 12", 6);
    edge_clr_i = 32'h1000;
    tick(); chk("R9 timer1 cleared", 0);
    edge_clr_i = '0;

    for (int n = 0; n < 3000; n++) begin
      irq_req_i   = $urandom & $urandom & $urandom;
      timer_hit_i = NT'($urandom & $urandom);
      edge_clr_i  = $urandom & $urandom;
      en_we_i     = (($urandom % 8) == 0);
      en_wdata_i  = $urandom;
      cur_level_i = LW'($urandom);
      tick();
      chk("R7 random", exp_level(m_pend, m_en, int'(cur_level_i)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule